// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is a single channel of a multi-channel counter/timer. Software programs it through a write-only register port. Each byte written is either a control word or a time constant. A control word is recognised by bit 0 being 1. A control word can announce that the following byte is a time constant. The channel runs an 8-bit down counter, and that counter can be read back at any moment. The counter reloads itself from the time constant each time it reaches zero, so the channel produces a steady stream of periodic events.

Two clock sources can drive the counter. In counter mode the source is an external trigger pin. The pin is brought into the system clock domain through a two-flop synchroniser, and then either its rising or its falling edge is detected. In timer mode the source is the system clock, divided by a prescaler of 16 or 256. A timer can also be held back until the first active edge arrives on the trigger pin. Every zero crossing gives a one-cycle pulse on a dedicated output. It can also raise an interrupt request, which stays high until the interrupt controller acknowledges it.

The register port and the trigger pin are plain control inputs. The block streams no data, so it has no valid/ready handshake and applies no back-pressure. A write is accepted in every cycle in which the write strobe is high.

Top module: `ctc_channel`

## Requirements
- R1: After reset the counter reads 0, the zero-count pulse and the interrupt request are low, and the channel is stopped.
- R2: A byte with bit 0 = 1 is a control word. Its bits are: 1 software reset, 2 time-constant-follows, 3 trigger-start, 4 rising edge (0 selects falling), 5 divide-by-256 (0 selects 16), 6 counter mode (0 selects timer), 7 interrupt enable. A byte with bit 0 = 0 is ignored when no time constant is pending.
- R3: After a control word with bit 2 set, the next byte written is the time constant. If the channel is stopped, that byte is also loaded into the counter and the channel starts.
- R4: In counter mode, each active edge of the trigger pin decrements the counter exactly once. A pin change set up before clock edge k shows up in the count after edge k+2. The inactive edge has no effect.
- R5: In timer mode the counter decrements once every 16 or 256 system clocks, as bit 5 selects. The first decrement comes 16 (or 256) clocks after the start.
- R6: In timer mode with bit 3 set, the loaded channel waits for an active trigger edge and does not count until that edge. The prescaler starts two clocks after the edge.
- R7: A decrement from 1 reloads the counter from the time constant. A time constant of 0 gives a period of 256 counts.
- R8: Every reload at zero produces `zc_pulse` high for exactly one clock, in the cycle after the reload edge.
- R9: A zero crossing with bit 7 set raises `irq`. It stays high until a cycle with `irq_ack` high clears it. With bit 7 clear, `irq` does not rise.
- R10: A software reset stops counting and reloads the counter from the kept time constant. A time constant written while the channel runs changes only the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, held at least 3 clocks |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Control word or time constant |
| trg_pin | input | 1 | External clock/trigger pin, asynchronous |
| irq_ack | input | 1 | Clears a pending interrupt request |
| cnt_q | output | 8 | Current down-counter value |
| zc_pulse | output | 1 | One-cycle zero-count/timeout pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- each counter change outside a write is either a single decrement or a reload,
- a reload always restores the time constant held before the edge,
- the zero pulse never lasts two cycles,
- the interrupt only rises together with a zero pulse,
- a stopped channel keeps its count.

Other behaviour can only be shown by the bench's scenarios, which compare against counts the bench computes itself. That covers the exact latency through the synchroniser, the prescaler period, trigger-start gating, the edge polarity, the encoding of the control word, and the retention of the time constant through a software reset.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int DW = 8;

  typedef struct packed {
    logic irq_en;
    logic ctr_mode;
    logic div_long;
    logic rise_sel;
    logic trig_start;
    logic tc_next;
    logic soft_rst;
    logic is_ctl;
  } ctc_ctrl_t;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_e;

endpackage

// File: rtl/ctc_edge_sync.sv
module ctc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_o
);
  logic [STAGES:0] sh;
  logic            cur, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign cur    = sh[STAGES-1];
  assign prev   = sh[STAGES];
  assign edge_o = rise_sel ? (cur & ~prev) : (~cur & prev);
endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
  parameter int SHORT_DIV = 16,
  parameter int LONG_DIV  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_long,
  output logic tick
);
  localparam int PW = $clog2(LONG_DIV);

  logic [PW-1:0] presc, lim;

  assign lim  = div_long ? PW'(LONG_DIV - 1) : PW'(SHORT_DIV - 1);
  assign tick = run && (presc == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) presc <= '0;
    else if (presc == lim) presc <= '0;
    else presc <= presc + 1'b1;
  end
endmodule

// File: rtl/ctc_downcounter.sv
module ctc_downcounter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic [W-1:0] tc,
  output logic [W-1:0] cnt,
  output logic         zero_evt
);
  assign zero_evt = dec && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (zero_evt) cnt <= tc;
    else if (dec)      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_DIV   = 16,
  parameter int LONG_DIV    = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          trg_pin,
  input  logic          irq_ack,
  output logic [DW-1:0] cnt_q,
  output logic          zc_pulse,
  output logic          irq
);
  ctc_ctrl_t     ctrl_q;
  logic [DW-1:0] tc_q;
  logic          tc_pend;
  ch_state_e     state;
  logic          running, wr_ctl, wr_tc, trg_edge, pre_tick;
  logic          load, dec, zero_evt;
  logic [DW-1:0] load_val;

  assign wr_tc   = wr_en && tc_pend;
  assign wr_ctl  = wr_en && !tc_pend && wr_data[0];
  assign running = (state == CH_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tc_q    <= '0;
      tc_pend <= 1'b0;
      state   <= CH_IDLE;
    end else if (wr_tc) begin
      tc_q    <= wr_data;
      tc_pend <= 1'b0;
      if (state == CH_IDLE)
        state <= (!ctrl_q.ctr_mode && ctrl_q.trig_start) ? CH_ARMED : CH_RUN;
    end else if (wr_ctl) begin
      ctrl_q  <= ctc_ctrl_t'(wr_data);
      tc_pend <= wr_data[2];
      if (wr_data[1]) state <= CH_IDLE;
    end else if (state == CH_ARMED && trg_edge) begin
      state <= CH_RUN;
    end
  end

  ctc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(trg_pin),
    .rise_sel(ctrl_q.rise_sel), .edge_o(trg_edge)
  );

  ctc_prescaler #(.SHORT_DIV(SHORT_DIV), .LONG_DIV(LONG_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running && !ctrl_q.ctr_mode),
    .div_long(ctrl_q.div_long), .tick(pre_tick)
  );

  assign load     = (wr_tc && state == CH_IDLE) || (wr_ctl && wr_data[1]);
  assign load_val = wr_tc ? wr_data : tc_q;
  assign dec      = running && !load && (ctrl_q.ctr_mode ? trg_edge : pre_tick);

  ctc_downcounter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .dec(dec), .tc(tc_q), .cnt(cnt_q), .zero_evt(zero_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc_pulse <= 1'b0;
      irq      <= 1'b0;
    end else begin
      zc_pulse <= zero_evt;
      if (zero_evt && ctrl_q.irq_en) irq <= 1'b1;
      else if (irq_ack)              irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ctc_channel_chk.sv
module ctc_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] cnt_q,
  input logic       zc_pulse,
  input logic       irq,
  input logic [7:0] tc_q,
  input logic       running
);
  // R8: zero pulse lasts one cycle
  assert_zc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |=> !zc_pulse);

  // R9: request rises only with a zero crossing
  assert_irq_on_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> zc_pulse);

  // R7: reload restores the time constant held before the edge
  assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse |-> cnt_q == $past(tc_q));

  // R4 / R5: any other change without a write is a single decrement
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !zc_pulse && !$stable(cnt_q)) |-> cnt_q == $past(cnt_q) - 8'd1);

  // R10: a stopped channel keeps its count
  assert_stopped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> $stable(cnt_q));
endmodule

bind ctc_channel ctc_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt_q(cnt_q),
  .zc_pulse(zc_pulse), .irq(irq), .tc_q(tc_q), .running(running)
);

// File: tb/sim_ctc_channel.sv
module sim_ctc_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       trg_pin = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] cnt_q;
  logic       zc_pulse, irq;

  int tests = 0, fails = 0, zc_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctc_channel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .trg_pin(trg_pin), .irq_ack(irq_ack), .cnt_q(cnt_q),
    .zc_pulse(zc_pulse), .irq(irq)
  );

  function automatic int exp_cnt(input int tc, input int t);
    int neff = (tc == 0) ? 256 : tc;
    return (tc - (t % neff)) & 255;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (zc_pulse) zc_cnt++;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    trg_pin = 1'b1; adv(4);
    trg_pin = 1'b0; adv(4);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_0c7c);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    adv(1);
    chk(cnt_q, 0, "R1 count");
    chk(zc_pulse, 0, "R1 zc");
    chk(irq, 0, "R1 irq");

    // R2: bytes with bit0 = 0 ignored when no constant pending
    wr(8'h06); wr(8'h2A); adv(2);
    chk(cnt_q, 0, "R2 ignored write");

    // R3: control then constant starts counter mode (rising)
    wr(8'h57); wr(8'd5);
    chk(cnt_q, 5, "R3 load");

    // R4: synchroniser latency and polarity
    trg_pin = 1'b1; adv(2);
    chk(cnt_q, 5, "R4 before sync");
    adv(1);
    chk(cnt_q, 4, "R4 after sync");
    adv(3); trg_pin = 1'b0; adv(4);
    chk(cnt_q, 4, "R4 falling ignored");
    pulse();
    chk(cnt_q, 3, "R4 second edge");

    // R10: constant written while running changes next reload only
    wr(8'h55); wr(8'd9);
    chk(cnt_q, 3, "R10 run tc write");
    zc_cnt = 0;
    pulse(); pulse();
    chk(cnt_q, 1, "R10 count on");
    pulse();
    chk(cnt_q, 9, "R7 reload new tc");
    chk(zc_cnt, 1, "R8 one pulse");

    // R2: ignored while running, mode unchanged
    wr(8'h00); adv(3);
    chk(cnt_q, 9, "R2 ignored run");
    pulse();
    chk(cnt_q, 8, "R2 still counter");

    // R10 / R4: soft reset reloads kept tc; falling mode
    wr(8'h47);
    chk(cnt_q, 9, "R10 keeps tc");
    wr(8'd4);
    trg_pin = 1'b1; adv(6);
    chk(cnt_q, 4, "R4 rising ignored");
    trg_pin = 1'b0; adv(6);
    chk(cnt_q, 3, "R4 falling counts");

    // R10: soft reset halts
    wr(8'h43);
    chk(cnt_q, 4, "R10 reset reload");
    pulse(); pulse();
    chk(cnt_q, 4, "R10 halted");

    // R5: timer divide by 16
    wr(8'h07); wr(8'd3); zc_cnt = 0;
    adv(15);
    chk(cnt_q, 3, "R5 before tick");
    adv(1);
    chk(cnt_q, 2, "R5 first tick");
    adv(32);
    chk(cnt_q, 3, "R7 timer reload");
    chk(zc_cnt, 1, "R8 timer pulse");
    chk(irq, 0, "R9 disabled");

    // R9: interrupt set and held until ack
    wr(8'h87); wr(8'd2);
    adv(31);
    chk(irq, 0, "R9 before zero");
    adv(1);
    chk(irq, 1, "R9 raised");
    adv(10);
    chk(irq, 1, "R9 held");
    irq_ack = 1'b1; adv(1); irq_ack = 1'b0;
    chk(irq, 0, "R9 acked");

    // R5: divide by 256
    wr(8'h27); wr(8'd2);
    adv(255);
    chk(cnt_q, 2, "R5 long before");
    adv(1);
    chk(cnt_q, 1, "R5 long tick");

    // R6: trigger start
    wr(8'h1F); wr(8'd5);
    adv(40);
    chk(cnt_q, 5, "R6 armed waits");
    trg_pin = 1'b1; adv(18);
    chk(cnt_q, 5, "R6 before tick");
    adv(1);
    chk(cnt_q, 4, "R6 started");
    trg_pin = 1'b0;

    // R7: constant 0 means 256
    wr(8'h07); wr(8'd0); zc_cnt = 0;
    adv(16);
    chk(cnt_q, 255, "R7 zero tc first");
    adv(4080);
    chk(cnt_q, 0, "R7 zero tc wrap");
    chk(zc_cnt, 1, "R8 wrap pulse");

    // Random counter-mode runs (R4, R7, R8)
    for (int i = 0; i < 20; i++) begin
      int tc, n;
      tc = int'($urandom_range(1, 20));
      n  = int'($urandom_range(0, 40));
      wr(8'h57); wr(8'(tc)); zc_cnt = 0;
      for (int j = 0; j < n; j++) pulse();
      chk(cnt_q, exp_cnt(tc, n), "R4 random count");
      chk(zc_cnt, n / tc, "R8 random pulses");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule